// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page tables from memory. A request carries the virtual address, whether the access is a store, and whether it comes from user mode. A root-table base input supplies the physical page of the first-level table. The walker reads one 32-bit entry per level through a word-addressed read port. It checks the flag bits of each entry and answers with either a physical address or a fault. A fault carries a cause code and the level at which it was found.

Each table is one 4 KB page holding 1024 entries of 32 bits. Bits 31:12 of an entry give the page frame of the next table or of the data page. The low bits of an entry hold flags. The walker handles one translation at a time. It accepts a request only while idle and copies the request and the root base at that moment. The memory port may stall the read request and may delay the read data for any number of cycles.

Top module: `pgw_walker`

## Requirements
- R1: The virtual address splits into a first-level index in bits 31:22, a second-level index in bits 21:12 and an offset in bits 11:0. The first read uses word address {root[31:12], va[31:22]}, which equals root frame plus index times 4 in bytes.
- R2: The second read uses word address {pte1[31:12], va[21:12]}, where pte1 is the first-level entry.
- R3: When both entries pass their checks, the response has rsp_fault=0, rsp_cause=0, rsp_level=0 and rsp_paddr={pte2[31:12], va[11:0]}.
- R4: An entry with flag bit 0 (present) clear gives a fault with rsp_cause=1. rsp_level is 1 or 2, naming the table that held the entry. A first-level fault ends the walk without a second read.
- R5: A store (req_store=1) whose entry at either level has flag bit 1 (writable) clear gives a fault with rsp_cause=2 at that level.
- R6: A user-mode access (req_user=1) whose entry at either level has flag bit 2 (user) clear gives a fault with rsp_cause=3 at that level.
- R7: The checks follow a fixed priority. The first level is checked before the second. Within one entry, not present wins over write protection, and write protection wins over user protection. A load from kernel mode needs only the present bit.
- R8: req_ready is high only while idle, so a single walk runs at a time. The request fields and root_base are taken in the accepting cycle, and later changes do not affect that walk.
- R9: mem_rd_valid stays high with a stable mem_rd_addr until mem_rd_ready. Read data is taken on mem_rsp_valid after any number of wait cycles.
- R10: rsp_valid is a single-cycle pulse. rsp_fault, rsp_cause, rsp_level and rsp_paddr are zero when rsp_valid is low.
- R11: After reset the walker is idle with req_ready=1, mem_rd_valid=0, rsp_valid=0 and rsp_fault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| root_base | input | 32 | Physical address of the first-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 30 | Word address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_paddr | output | 32 | Physical address on success |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write protection, 3 user protection |
| rsp_level | output | 2 | Level of the faulting entry (1 or 2), 0 on success |

## Verification
The hardest cases are faults at the second level after a valid first-level entry, and fault priority when several flag bits are clear at once. Both need the bench to serve two chosen entries at the exact addresses the walk should compute. The bench therefore acts as the memory. It answers each read with an entry it builds per walk and checks every read address against its own index arithmetic. It adds random stalls on both memory handshakes and changes root_base while a walk runs. The flag bits are drawn at random with a bias toward present entries, so second-level checks happen often. Directed walks cover each cause at each level and the priority order.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int LEVELS = 2;
  localparam int WORD_AW = PA_W - 2;
  localparam int FRAME_W = PA_W - OFF_W;

  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WRITE  = 2'd2,
    CAUSE_USER   = 2'd3
  } fault_cause_t;

  // Index for level lvl (0 = first level, taken from the top bits).
  function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va, input int lvl);
    return va[OFF_W + IDX_W*(LEVELS-1-lvl) +: IDX_W];
  endfunction

  // Byte address of the entry, then reduced to a word address.
  function automatic logic [WORD_AW-1:0] entry_word(input logic [FRAME_W-1:0] frame,
                                                    input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] byte_addr;
    byte_addr = {frame, {OFF_W{1'b0}}} + PA_W'({idx, 2'b00});
    return byte_addr[PA_W-1:2];
  endfunction

  // Final physical address: page frame joined with the page offset.
  function automatic logic [PA_W-1:0] join_paddr(input logic [FRAME_W-1:0] frame,
                                                 input logic [VA_W-1:0] va);
    return {frame, va[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr
  import pgw_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [WORD_AW-1:0] word_addr
);
  always_comb word_addr = entry_word(frame, idx);
endmodule

// File: rtl/pgw_perm_check.sv
module pgw_perm_check
  import pgw_pkg::*;
(
  input  logic [PA_W-1:0] entry,
  input  logic            is_store,
  input  logic            is_user,
  output logic            fault,
  output logic [1:0]      cause
);
  fault_cause_t c;

  always_comb begin
    if (!entry[FLAG_PRESENT])                 c = CAUSE_ABSENT;
    else if (is_store && !entry[FLAG_WRITE])  c = CAUSE_WRITE;
    else if (is_user && !entry[FLAG_USER])    c = CAUSE_USER;
    else                                      c = CAUSE_NONE;
  end

  assign cause = c;
  assign fault = (c != CAUSE_NONE);
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int LVL_W = $clog2(LEVELS + 1),
  parameter int CNT_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_store,
  input  logic               req_user,
  input  logic [PA_W-1:0]    root_base,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [WORD_AW-1:0] mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [LVL_W-1:0]   rsp_level
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WT, ST_RESP} walk_state_t;

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q;
  logic               store_q, user_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [CNT_W-1:0]   lvl_q;
  logic [PA_W-1:0]    paddr_q;
  logic               fault_q;
  logic [1:0]         cause_q;
  logic [LVL_W-1:0]   level_q;

  // Named events for the checker.
  logic acc_fire, rd_fire, ent_fire, last_level, walk_fault;
  logic [1:0] chk_cause;

  logic [WORD_AW-1:0] lvl_addr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pgw_entry_addr u_ea (
      .frame     (tbl_q),
      .idx       (va_index(va_q, g)),
      .word_addr (lvl_addr[g])
    );
  end

  pgw_perm_check u_chk (
    .entry    (mem_rsp_data),
    .is_store (store_q),
    .is_user  (user_q),
    .fault    (walk_fault),
    .cause    (chk_cause)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign acc_fire   = req_valid && req_ready;
  assign mem_rd_valid = (state_q == ST_RD);
  assign mem_rd_addr  = lvl_addr[lvl_q];
  assign rd_fire    = mem_rd_valid && mem_rd_ready;
  assign ent_fire   = (state_q == ST_WT) && mem_rsp_valid;
  assign last_level = (int'(lvl_q) == LEVELS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      store_q <= 1'b0;
      user_q  <= 1'b0;
      tbl_q   <= '0;
      lvl_q   <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
      level_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc_fire) begin
          va_q    <= req_vaddr;
          store_q <= req_store;
          user_q  <= req_user;
          tbl_q   <= root_base[PA_W-1:OFF_W];
          lvl_q   <= '0;
          state_q <= ST_RD;
        end
        ST_RD: if (rd_fire) state_q <= ST_WT;
        ST_WT: if (ent_fire) begin
          if (walk_fault) begin
            fault_q <= 1'b1;
            cause_q <= chk_cause;
            level_q <= LVL_W'(lvl_q) + LVL_W'(1);
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else if (last_level) begin
            fault_q <= 1'b0;
            cause_q <= '0;
            level_q <= '0;
            paddr_q <= join_paddr(mem_rsp_data[PA_W-1:OFF_W], va_q);
            state_q <= ST_RESP;
          end else begin
            tbl_q   <= mem_rsp_data[PA_W-1:OFF_W];
            lvl_q   <= lvl_q + CNT_W'(1);
            state_q <= ST_RD;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = rsp_valid && fault_q;
  assign rsp_cause = rsp_valid ? cause_q : 2'd0;
  assign rsp_level = rsp_valid ? level_q : '0;
  assign rsp_paddr = rsp_valid ? paddr_q : '0;

endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [29:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_cause,
  input logic [1:0]  rsp_level,
  input logic [31:0] rsp_paddr,
  input logic        ent_fire,
  input logic        walk_fault,
  input logic        last_level
);

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  a_r8_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid && !rsp_valid);

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_fault && rsp_cause == 2'd0 && rsp_level == 2'd0 && rsp_paddr == 32'd0);

  a_r3_ok_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0 && rsp_level == 2'd0);

  a_r4_fault_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_cause != 2'd0 && (rsp_level == 2'd1 || rsp_level == 2'd2));

  a_r4_l1_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ent_fire && walk_fault && !last_level |=> rsp_valid && rsp_fault && rsp_level == 2'd1);

  a_r2_continue: assert property (@(posedge clk) disable iff (!rst_n)
    ent_fire && !walk_fault && !last_level |=> mem_rd_valid);

endmodule

bind pgw_walker pgw_walker_chk u_pgw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_cause    (rsp_cause),
  .rsp_level    (rsp_level),
  .rsp_paddr    (rsp_paddr),
  .ent_fire     (ent_fire),
  .walk_fault   (walk_fault),
  .last_level   (last_level)
);

// File: tb/pgw_walker_tb.sv
module pgw_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] root_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [29:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [1:0]  rsp_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pgw_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_user(req_user), .root_base(root_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Flag checks as the requirements order them (R4, R5, R6, R7).
  function automatic logic [1:0] flag_cause(input logic [31:0] e, input bit st, input bit us);
    if (!e[0])            return 2'd1;
    else if (st && !e[1]) return 2'd2;
    else if (us && !e[2]) return 2'd3;
    else                  return 2'd0;
  endfunction

  task automatic walk(input logic [31:0] va, input bit st, input bit us,
                      input logic [31:0] base, input logic [31:0] e1, input logic [31:0] e2);
    logic [29:0] a1, a2;
    logic [1:0]  c1, c2, exp_cause, exp_level;
    logic [31:0] exp_pa;
    int exp_reads, nreads, lat, cyc;
    bit pend, got;
    logic [31:0] pend_data;

    a1 = {base[31:12], va[31:22]};
    a2 = {e1[31:12], va[21:12]};
    c1 = flag_cause(e1, st, us);
    c2 = flag_cause(e2, st, us);
    if (c1 != 0) begin
      exp_cause = c1; exp_level = 2'd1; exp_pa = 0; exp_reads = 1;
    end else if (c2 != 0) begin
      exp_cause = c2; exp_level = 2'd2; exp_pa = 0; exp_reads = 2;
    end else begin
      exp_cause = 0; exp_level = 0; exp_pa = {e2[31:12], va[11:0]}; exp_reads = 2;
    end

    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = us; root_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom; req_store = ~st; req_user = ~us;
    root_base = $urandom;                     // R8: must not affect this walk
    check(!req_ready, "R8", "req_ready while busy", {31'd0, req_ready}, 32'd0);

    nreads = 0; pend = 0; got = 0; cyc = 0; lat = 0; pend_data = 0;
    while (!got && cyc < 100) begin
      mem_rsp_valid = 1'b0;
      mem_rd_ready  = 1'b0;
      if (rsp_valid) begin
        got = 1;
      end else begin
        if (pend) begin
          if (lat == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; pend = 0;
          end else lat--;
        end else if (mem_rd_valid) begin
          if ($urandom % 3 != 0) begin
            mem_rd_ready = 1'b1;
            if (nreads == 0) begin
              check(mem_rd_addr == a1, "R1", "first entry address", {2'b0, mem_rd_addr}, {2'b0, a1});
              pend_data = e1;
            end else begin
              check(mem_rd_addr == a2, "R2", "second entry address", {2'b0, mem_rd_addr}, {2'b0, a2});
              pend_data = e2;
            end
            nreads++;
            pend = 1;
            lat = $urandom % 4;
          end
        end
        @(negedge clk);
        cyc++;
      end
    end
    mem_rsp_valid = 1'b0; mem_rd_ready = 1'b0;

    check(got, "R9", "response arrived", {31'd0, got}, 32'd1);
    if (got) begin
      check(nreads == exp_reads, "R4", "entry reads", nreads, exp_reads);
      check(rsp_fault == (exp_cause != 0), exp_cause == 0 ? "R3" : "R4", "fault flag",
            {31'd0, rsp_fault}, {31'd0, exp_cause != 0});
      check(rsp_cause == exp_cause, exp_cause == 2 ? "R5" : (exp_cause == 3 ? "R6" : "R7"),
            "cause", {30'd0, rsp_cause}, {30'd0, exp_cause});
      check(rsp_level == exp_level, "R7", "level", {30'd0, rsp_level}, {30'd0, exp_level});
      check(rsp_paddr == exp_pa, "R3", "physical address", rsp_paddr, exp_pa);
      @(negedge clk);
      check(!rsp_valid && !rsp_fault, "R10", "pulse ends", {31'd0, rsp_valid}, 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd_valid && !rsp_valid && !rsp_fault, "R11", "reset outputs",
          {28'd0, req_ready, mem_rd_valid, rsp_valid, rsp_fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_rd_valid && !rsp_valid, "R11", "idle after reset",
          {29'd0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);

    // Directed corner cases.
    walk(32'h0020_0ffc, 0, 1, 32'hffff_1000, 32'hf0f0_2007, 32'hff00_5007); // R3 example
    walk(32'h0020_0ffc, 1, 1, 32'hffff_1000, 32'hf0f0_2006, 32'hff00_5007); // R4 level 1
    walk(32'h1234_5678, 0, 0, 32'h0000_3000, 32'h0004_4007, 32'h0005_5006); // R4 level 2
    walk(32'hffff_ffff, 1, 0, 32'h0010_0000, 32'h0020_0005, 32'h0030_0007); // R5 level 1
    walk(32'h8000_1000, 1, 1, 32'h0010_0000, 32'h0020_0007, 32'h0030_0005); // R5 level 2
    walk(32'h4000_0abc, 0, 1, 32'h00a0_0000, 32'h00b0_0003, 32'h00c0_0007); // R6 level 1
    walk(32'h4000_0abc, 0, 1, 32'h00a0_0000, 32'h00b0_0007, 32'h00c0_0003); // R6 level 2
    walk(32'h0040_1000, 1, 1, 32'h00a0_0000, 32'h00b0_0000, 32'h00c0_0007); // R7 absent first
    walk(32'h0040_1000, 1, 1, 32'h00a0_0000, 32'h00b0_0001, 32'h00c0_0007); // R7 write before user
    walk(32'h0040_1000, 0, 0, 32'h00a0_0000, 32'h00b0_0001, 32'h00c0_0001); // R7 kernel load

    // Random walks, flags biased toward present.
    for (int i = 0; i < 80; i++) begin
      logic [31:0] e1, e2;
      e1 = $urandom; e2 = $urandom;
      if ($urandom % 5 != 0) e1[0] = 1'b1;
      if ($urandom % 5 != 0) e2[0] = 1'b1;
      walk($urandom, 1'($urandom), 1'($urandom), $urandom, e1, e2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule